// File: doc/BRIEF.md
# Extended Match Channel Bank

This block is a bank of eight timer channels, numbered 4 to 11. Each channel has a counter, a match value and a control word, all reached through a small register port. A channel counts on the strobes of one tick rate, chosen from five inputs (32 768 Hz, 1 kHz, 1 Hz, 1 MHz and an external source). When the counter it compares against reaches its match value, the channel fires. A firing channel can raise a status bit, clear its own counter and stay armed for the next period. Tick generation is outside the block: each rate arrives as a one-cycle strobe on `tick_i`.

Channels are grouped. Channel 4 leads channels 4 to 7, channel 8 leads 8 and 9, and channel 10 leads 10 and 11. A follower whose own-counter bit is clear compares against its leader's counter and leaves its own counter idle. A follower whose own-counter bit is set runs on its own counter. Channels 8 to 11 have a wider control word. It adds a halt bit and, on channels 9 and 11, a snapshot bit. With the snapshot bit set, a read of the channel's counter also copies its leader's count into a snapshot register. All status bits drive one shared interrupt line.

The register port has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and the snapshot capture happens at that edge.

Top module: `tmr_ext_bank`

## Requirements
- R1: Register map, with k = channel − 4 (0..7). Match value is at 0x80+4k, counter at 0x40+4k, control word at 0xC0+4k. Status is at 0x14, with channel c in bit c. Snapshot is at 0x20. Any other address reads 0.
- R2: Control bits 2:0 select the count rate. Codes 1, 2, 3, 4 and 5 pick `tick_i` bits 0, 1, 2, 3 and 4. Codes 0, 6 and 7 stop the counter. A running counter goes up by one only in a cycle where its selected strobe is high.
- R3: Control bit 7 set makes a channel use its own counter. On a follower (channels 5–7, 9, 11), bit 7 clear makes the channel compare against its leader's counter, and its own counter does not advance. Leaders 4, 8 and 10 always use their own counter.
- R4: An armed channel fires at the clock edge where the counter it compares against advances to its match value. Status bit (4+k) is set at that edge only if `irq_en_i[k]` is 1.
- R5: With control bit 3 set, a channel firing on its own counter loads 0 instead of the match value.
- R6: With control bit 6 clear, a channel disarms after firing and ignores later matches until its control word or match value is written. Writing its counter does not re-arm it. With bit 6 set it stays armed.
- R7: Control words of channels 4–7 keep bits 7:0. Those of channels 8–11 keep bits 9:0. Unkept bits read as 0.
- R8: On channels 8–11, control bit 8 stops the counter whatever bits 2:0 select.
- R9: A read of the counter of channel 9 or 11 with its control bit 9 set copies the current count of channel 8 or 10 into the snapshot register. Any other access leaves the snapshot unchanged.
- R10: Writing ones to status bits clears them. If a channel fires in the same cycle, its set wins. `irq_o` is high exactly while any status bit is set.
- R11: Reset clears every counter, match value, control word, status bit and the snapshot, and arms every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers snapshot capture) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tick_i | input | NRATE (5) | One-cycle rate strobes: 32 768 Hz, 1 kHz, 1 Hz, 1 MHz, external |
| irq_en_i | input | 8 | Per-channel status enable, bit k for channel 4+k |
| irq_o | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
The bench builds the bank with an 8-bit counter (CNT_W = 8) and keeps the five default rate inputs. A narrow counter keeps match values, counter readback and the snapshot copy small and easy to predict. Every rate-select code, including the stopped codes and the external strobe, can be driven in a few cycles. Group sharing, reset-on-match periodic firing and one-shot disarm all need only short tick bursts, so each can be exercised on its own with the others held stopped.

// File: rtl/tmr_ext_pkg.sv
package tmr_ext_pkg;
  localparam int NCH     = 8;  // channels in the bank
  localparam int CH_BASE = 4;  // number of the first channel, also its status bit
  localparam int CTRL_W  = 10;

  // control word bit positions
  localparam int B_CLR  = 3;   // zero own counter on match
  localparam int B_PER  = 6;   // stay armed after match
  localparam int B_OWN  = 7;   // run on own counter
  localparam int B_HALT = 8;   // wide channels: force stop
  localparam int B_SNAP = 9;   // channels 9/11: snapshot on counter read

  // address regions, bits 7:5 of the byte address
  localparam logic [2:0] RG_CNT   = 3'b010;
  localparam logic [2:0] RG_MATCH = 3'b100;
  localparam logic [2:0] RG_CTRL  = 3'b110;
  localparam logic [7:0] A_STAT   = 8'h14;
  localparam logic [7:0] A_SNAP   = 8'h20;

  function automatic int leader_of(input int k);
    if (k < 4) return 0;
    else if (k < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/tmr_rate_mux.sv
module tmr_rate_mux #(
  parameter int NRATE = 5
) (
  input  logic [2:0]       sel,
  input  logic             halt,
  input  logic [NRATE-1:0] ticks,
  output logic             adv
);
  always_comb begin
    adv = 1'b0;
    for (int r = 0; r < NRATE; r++) begin
      if (!halt && sel == 3'(r + 1)) adv = ticks[r];
    end
  end
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_ext_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NRATE = 5,
  parameter bit WIDE  = 1'b0,
  parameter bit LEAD  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              match_we,
  input  logic              cnt_we,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic [CNT_W-1:0]  val_wd,
  input  logic [NRATE-1:0]  ticks,
  input  logic [CNT_W-1:0]  lead_cnt,
  input  logic              lead_adv,
  output logic [CNT_W-1:0]  own_cnt,
  output logic              own_adv,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  match_q,
  output logic              fire
);
  localparam logic [CTRL_W-1:0] KEEP = WIDE ? 10'h3FF : 10'h0FF;
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic             armed;
  logic             use_own;
  logic             halt;
  logic [CNT_W-1:0] src_cnt;
  logic             src_adv;

  assign use_own = LEAD || ctrl_q[B_OWN];
  assign halt    = (WIDE && ctrl_q[B_HALT]) || !use_own;

  tmr_rate_mux #(.NRATE(NRATE)) u_rate (
    .sel  (ctrl_q[2:0]),
    .halt (halt),
    .ticks(ticks),
    .adv  (own_adv)
  );

  assign src_cnt = use_own ? own_cnt : lead_cnt;
  assign src_adv = use_own ? own_adv : lead_adv;
  assign fire    = armed && src_adv && ((src_cnt + ONE) == match_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      own_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_wd & KEEP;
      if (match_we) match_q <= val_wd;
      if (ctrl_we || match_we)      armed <= 1'b1;
      else if (fire && !ctrl_q[B_PER]) armed <= 1'b0;
      if (cnt_we) own_cnt <= val_wd;
      else if (own_adv) begin
        if (fire && use_own && ctrl_q[B_CLR]) own_cnt <= '0;
        else                                  own_cnt <= own_cnt + ONE;
      end
    end
  end

  AST_REARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || match_we) |=> armed); // R6
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl_q[B_PER] && !ctrl_we && !match_we) |=> !armed); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_adv && !cnt_we) |=> $stable(own_cnt)); // R2
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && use_own && ctrl_q[B_CLR] && !cnt_we) |=> (own_cnt == '0)); // R5
  AST_FOLLOWER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_own && !cnt_we) |=> $stable(own_cnt)); // R3
endmodule

// File: rtl/tmr_ext_bank.sv
module tmr_ext_bank
  import tmr_ext_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NRATE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NRATE-1:0] tick_i,
  input  logic [NCH-1:0]   irq_en_i,
  output logic             irq_o
);
  localparam int SLOT_W = $clog2(NCH);

  logic [SLOT_W-1:0] slot;
  logic              sel_cnt, sel_match, sel_ctrl, sel_stat;

  logic [CNT_W-1:0]  cnt_a   [NCH];
  logic [CNT_W-1:0]  match_a [NCH];
  logic [CTRL_W-1:0] ctrl_a  [NCH];
  logic [NCH-1:0]    adv_v;
  logic [NCH-1:0]    fire_v;
  logic [NCH-1:0]    stat_q;
  logic [NCH-1:0]    stat_clr;
  logic [CNT_W-1:0]  snap_q;
  logic [CNT_W-1:0]  snap_src;
  logic              snap_cap;

  assign slot      = bus_addr[SLOT_W+1:2];
  assign sel_cnt   = (bus_addr[7:5] == RG_CNT)   && (bus_addr[1:0] == 2'b00);
  assign sel_match = (bus_addr[7:5] == RG_MATCH) && (bus_addr[1:0] == 2'b00);
  assign sel_ctrl  = (bus_addr[7:5] == RG_CTRL)  && (bus_addr[1:0] == 2'b00);
  assign sel_stat  = (bus_addr == A_STAT);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int LD = leader_of(k);
    logic hit;
    assign hit = (slot == SLOT_W'(k));

    tmr_match_chan #(
      .CNT_W(CNT_W),
      .NRATE(NRATE),
      .WIDE (k >= 4),
      .LEAD (k == LD)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (bus_wr && sel_ctrl && hit),
      .match_we(bus_wr && sel_match && hit),
      .cnt_we  (bus_wr && sel_cnt && hit),
      .ctrl_wd (bus_wdata[CTRL_W-1:0]),
      .val_wd  (bus_wdata[CNT_W-1:0]),
      .ticks   (tick_i),
      .lead_cnt(cnt_a[LD]),
      .lead_adv(adv_v[LD]),
      .own_cnt (cnt_a[k]),
      .own_adv (adv_v[k]),
      .ctrl_q  (ctrl_a[k]),
      .match_q (match_a[k]),
      .fire    (fire_v[k])
    );

    AST_STATUS_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_v[k] && irq_en_i[k]) |=> stat_q[k]); // R4
    AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[k] && !(fire_v[k] && irq_en_i[k])) |=> !stat_q[k]); // R4
  end

  // status: fires set, ones written clear, set wins
  assign stat_clr = (bus_wr && sel_stat) ? bus_wdata[CH_BASE +: NCH] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | (fire_v & irq_en_i);
  end

  assign irq_o = |stat_q;

  // snapshot: reading counter of an odd wide channel copies its leader
  always_comb begin
    snap_cap = 1'b0;
    snap_src = '0;
    for (int k = 5; k < NCH; k += 2) begin
      if (bus_rd && sel_cnt && slot == SLOT_W'(k) && ctrl_a[k][B_SNAP]) begin
        snap_cap = 1'b1;
        snap_src = cnt_a[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '0;
    else if (snap_cap) snap_q <= snap_src;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_cnt)               bus_rdata = 32'(cnt_a[slot]);
      else if (sel_match)        bus_rdata = 32'(match_a[slot]);
      else if (sel_ctrl)         bus_rdata = 32'(ctrl_a[slot]);
      else if (sel_stat)         bus_rdata[CH_BASE +: NCH] = stat_q;
      else if (bus_addr == A_SNAP) bus_rdata = 32'(snap_q);
    end
  end

  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_stat && (&bus_wdata[CH_BASE +: NCH]) && !(|(fire_v & irq_en_i)))
      |=> !irq_o); // R10
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cap |=> $stable(snap_q)); // R9
endmodule

// File: tb/test_tmr_ext_bank.sv
`timescale 1ns/1ps
module test_tmr_ext_bank;
  localparam int CNT_W = 8;
  localparam int NRATE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NRATE-1:0] tick_i = '0;
  logic [7:0]  irq_en_i = 8'hFF;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_ext_bank #(.CNT_W(CNT_W), .NRATE(NRATE)) i_tmr_ext_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-compare, 2 tick burst
    logic [7:0]  addr;
    logic [31:0] data; // write data or tick mask
    logic [31:0] exp;  // read value or tick count
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'hC0, 32'h001, 32'd0,   4'd2},  // R2 ch4 on 32 kHz
    '{2'd2, 8'h00, 32'h01,  32'd3,   4'd2},
    '{2'd1, 8'h40, 32'h0,   32'd3,   4'd2},
    '{2'd2, 8'h00, 32'h02,  32'd2,   4'd2},  // R2 other rate ignored
    '{2'd1, 8'h40, 32'h0,   32'd3,   4'd2},
    '{2'd2, 8'h00, 32'h1C,  32'd2,   4'd2},
    '{2'd1, 8'h40, 32'h0,   32'd3,   4'd2},
    '{2'd0, 8'h80, 32'd5,   32'd0,   4'd4},  // R4 match 5
    '{2'd2, 8'h00, 32'h01,  32'd2,   4'd4},
    '{2'd1, 8'h14, 32'h0,   32'h010, 4'd4},
    '{2'd0, 8'h14, 32'h010, 32'd0,   4'd10}, // R10 clear
    '{2'd1, 8'h14, 32'h0,   32'h000, 4'd10},
    '{2'd0, 8'h40, 32'd3,   32'd0,   4'd6},  // R6 counter write no re-arm
    '{2'd2, 8'h00, 32'h01,  32'd2,   4'd6},
    '{2'd1, 8'h14, 32'h0,   32'h000, 4'd6},
    '{2'd1, 8'h40, 32'h0,   32'd5,   4'd6},
    '{2'd0, 8'h84, 32'd7,   32'd0,   4'd3},  // R3 ch5 follows ch4
    '{2'd2, 8'h00, 32'h01,  32'd2,   4'd3},
    '{2'd1, 8'h14, 32'h0,   32'h020, 4'd3},
    '{2'd1, 8'h44, 32'h0,   32'd0,   4'd3},
    '{2'd0, 8'h14, 32'hFF0, 32'd0,   4'd10},
    '{2'd0, 8'hC0, 32'h000, 32'd0,   4'd2},
    '{2'd0, 8'hC4, 32'h3FF, 32'd0,   4'd7},  // R7 narrow keeps 7:0
    '{2'd1, 8'hC4, 32'h0,   32'h0FF, 4'd7},
    '{2'd0, 8'hD0, 32'h3FF, 32'd0,   4'd7},  // R7 wide keeps 9:0
    '{2'd1, 8'hD0, 32'h0,   32'h3FF, 4'd7},
    '{2'd0, 8'hC4, 32'h000, 32'd0,   4'd7},
    '{2'd0, 8'hD0, 32'h184, 32'd0,   4'd8},  // R8 halt bit
    '{2'd2, 8'h00, 32'h08,  32'd3,   4'd8},
    '{2'd1, 8'h50, 32'h0,   32'd0,   4'd8},
    '{2'd0, 8'hD0, 32'h084, 32'd0,   4'd8},
    '{2'd2, 8'h00, 32'h08,  32'd3,   4'd8},
    '{2'd1, 8'h50, 32'h0,   32'd3,   4'd8},
    '{2'd0, 8'h98, 32'd3,   32'd0,   4'd5},  // R5 ch10 periodic, clear on match
    '{2'd0, 8'hD8, 32'h049, 32'd0,   4'd5},
    '{2'd2, 8'h00, 32'h01,  32'd3,   4'd5},
    '{2'd1, 8'h14, 32'h0,   32'h400, 4'd5},
    '{2'd1, 8'h58, 32'h0,   32'd0,   4'd5},
    '{2'd0, 8'h14, 32'h400, 32'd0,   4'd10},
    '{2'd2, 8'h00, 32'h01,  32'd3,   4'd6},
    '{2'd1, 8'h14, 32'h0,   32'h400, 4'd6},  // R6 periodic fires again
    '{2'd0, 8'h14, 32'h400, 32'd0,   4'd10},
    '{2'd0, 8'hD8, 32'h000, 32'd0,   4'd5},
    '{2'd0, 8'hD4, 32'h200, 32'd0,   4'd9},  // R9 snapshot enable on ch9
    '{2'd1, 8'h54, 32'h0,   32'd0,   4'd9},
    '{2'd1, 8'h20, 32'h0,   32'd3,   4'd9},
    '{2'd0, 8'hD4, 32'h000, 32'd0,   4'd9},
    '{2'd2, 8'h00, 32'h08,  32'd2,   4'd9},
    '{2'd1, 8'h54, 32'h0,   32'd0,   4'd9},
    '{2'd1, 8'h20, 32'h0,   32'd3,   4'd9},
    '{2'd1, 8'h24, 32'h0,   32'd0,   4'd1},  // R1 unmapped, readbacks
    '{2'd1, 8'h98, 32'h0,   32'd3,   4'd1},
    '{2'd1, 8'h50, 32'h0,   32'd5,   4'd1}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 check(bus_rdata, e, tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tk(input logic [NRATE-1:0] m, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick_i = m;
    end
    @(negedge clk); tick_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({31'd0, irq_o}, 32'd0, "R11 irq after reset");
    rst_n = 1'b1;
    rd(8'h14, 32'h0, "R11 status after reset");
    rd(8'h40, 32'h0, "R11 counter after reset");
    rd(8'hD0, 32'h0, "R11 control after reset");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
        default: tk(VEC[i].data[NRATE-1:0], int'(VEC[i].exp));
      endcase
    end

    // R4 masked enable: fire without status
    irq_en_i = 8'hFE;
    wr(8'h80, 32'd9);
    wr(8'hC0, 32'h001);
    tk(5'h01, 2);
    check({31'd0, irq_o}, 32'd0, "R4 masked irq");
    rd(8'h14, 32'h0, "R4 masked status");

    // R10 two sources on the shared line
    irq_en_i = 8'hFF;
    wr(8'h80, 32'd11);
    wr(8'h84, 32'd11);
    tk(5'h01, 2);
    rd(8'h14, 32'h030, "R10 two bits set");
    check({31'd0, irq_o}, 32'd1, "R10 irq high");
    wr(8'h14, 32'h010);
    check({31'd0, irq_o}, 32'd1, "R10 irq stays with one bit");
    rd(8'h14, 32'h020, "R10 one bit left");
    wr(8'h14, 32'h020);
    check({31'd0, irq_o}, 32'd0, "R10 irq drops");
    wr(8'hC0, 32'h000);

    // R2 external rate and stop codes on ch6
    wr(8'hC8, 32'h085);
    tk(5'h10, 2);
    rd(8'h48, 32'd2, "R2 external strobe");
    tk(5'h0F, 2);
    rd(8'h48, 32'd2, "R2 other strobes ignored");
    wr(8'hC8, 32'h086);
    tk(5'h1F, 2);
    rd(8'h48, 32'd2, "R2 code 6 stopped");
    wr(8'hC8, 32'h080);
    tk(5'h1F, 2);
    rd(8'h48, 32'd2, "R2 code 0 stopped");

    // R11 reset mid-run
    wr(8'hC8, 32'h085);
    wr(8'h88, 32'd3);
    tk(5'h10, 3);
    check({31'd0, irq_o}, 32'd1, "R11 irq before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check({31'd0, irq_o}, 32'd0, "R11 irq in reset");
    rst_n = 1'b1;
    rd(8'h48, 32'h0, "R11 counter cleared");
    rd(8'hC8, 32'h0, "R11 control cleared");
    rd(8'h14, 32'h0, "R11 status cleared");
    rd(8'h20, 32'h0, "R11 snapshot cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule